// File: doc/BRIEF.md
# Masked I2C Target Register Bank

This block is the register file behind an I2C target byte engine. The engine has already handled bit timing and address matching. It hands the bank one byte-level event per cycle: a start (or repeated start), a received write byte, a request for a read byte, or a stop. The bank answers on its own, with no help from a host during a transfer. It keeps a register pointer and applies a per-bit read mask and a per-bit write mask to every bus access.

Two addressing schemes are available. In pointer mode, the first data byte of a bus write sets the pointer. Each register that the bus then reads or writes moves the pointer on by one. In zero mode, every transfer begins at register 0.

A separate host port reads and writes the register contents, both masks, the pointer, the active register count and the mode. The host port is never masked. When the host and the bus collide, the bus wins and the host sees its acknowledge held low, so it retries the access.

Top module: `i2c_tgt_regbank`

## Requirements
- R1: After reset every register reads 0xFF, every read mask and write mask is 0xFF, the pointer is 0, the count field reads 0xFF (256 registers) and the mode is pointer mode (0).
- R2: A host write of value n to control address 1 sets the active count to n+1, limited to NUM_REGS. Reading control address 1 returns the count minus one.
- R3: When the pointer advances from count-1 it wraps to 0. Any pointer load, whether from the bus or the host, is reduced modulo the active count.
- R4: Bus event codes are 0 start, 1 write byte, 2 read byte and 3 stop. In pointer mode, the first write byte after a start loads the pointer, and later write bytes go to successive registers.
- R5: A read-byte event takes the byte at the pointer. The pointer then advances by one after every register read or written on the bus.
- R6: In zero mode (mode bit 1), a start or repeated start sets the pointer to 0, and every write byte, the first included, is stored in a register.
- R7: Bus read data has a 0 in every bit whose read-mask bit is 0.
- R8: A bus write changes only the register bits whose write-mask bit is 1. The other bits keep their old value.
- R9: Host reads return raw register contents and host writes set all 8 bits, whatever the masks hold.
- R10: host_sel encodes 0 data, 1 read mask, 2 write mask and 3 control. Control address 0 is the pointer, 1 is the count minus one, and 2 is the mode in bit 0 (0 pointer, 1 zero).
- R11: A host write to the register the bus writes in the same cycle, or a host control write during any bus event, gets host_ack 0 and has no effect. The bus write is kept.
- R12: bus_rdata shows the masked register at the pointer in the same cycle, including right after a host write. A stop event leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ev_valid | input | 1 | A byte event is present this cycle |
| bus_ev_kind | input | 2 | Event code: 0 start, 1 write, 2 read, 3 stop |
| bus_ev_data | input | 8 | Received byte for write events |
| bus_rdata | output | 8 | Masked byte at the pointer for the engine to send |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_sel | input | 2 | Target: data, read mask, write mask, control |
| host_addr | input | 8 | Register index or control address |
| host_wdata | input | 8 | Host write value |
| host_ack | output | 1 | Access accepted this cycle |
| host_rdata | output | 8 | Host read value, combinational |

## Verification
The hardest case to reach is a collision: the host writes a register in the very cycle the bus writes that same register. To get there, the stimulus first places the pointer with a bus write, then drives the next bus write byte and the host write in the same cycle. It checks that the acknowledge is held low, that the bus byte survived, and that the retry then lands. A host control write during a stop event is driven the same way to show the stall, and the pointer is then read back to show the stop left it unchanged.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int RB_DW       = 8;
    localparam int RB_IW       = 8;
    localparam int RB_CW       = RB_IW + 1;
    localparam int RB_MAX_REGS = 1 << RB_IW;

    typedef logic [RB_DW-1:0] rb_byte_t;
    typedef logic [RB_IW-1:0] rb_idx_t;
    typedef logic [RB_CW-1:0] rb_cnt_t;

    typedef enum logic [1:0] {
        EV_START = 2'd0,
        EV_WRITE = 2'd1,
        EV_READ  = 2'd2,
        EV_STOP  = 2'd3
    } bus_ev_e;

    typedef enum logic [1:0] {
        HS_DATA  = 2'd0,
        HS_RMASK = 2'd1,
        HS_WMASK = 2'd2,
        HS_CTRL  = 2'd3
    } host_sel_e;

    typedef enum logic {
        MODE_PTR  = 1'b0,
        MODE_ZERO = 1'b1
    } addr_mode_e;

    localparam rb_idx_t CTRL_PTR  = 8'd0;
    localparam rb_idx_t CTRL_CNT  = 8'd1;
    localparam rb_idx_t CTRL_MODE = 8'd2;

    typedef struct packed {
        rb_byte_t data;
        rb_byte_t rmask;
        rb_byte_t wmask;
    } rb_entry_t;

    typedef struct packed {
        logic     en;
        rb_idx_t  idx;
        rb_byte_t val;
    } rb_wr_t;

    typedef struct packed {
        logic      en;
        host_sel_e sel;
        rb_idx_t   idx;
        rb_byte_t  val;
    } rb_host_wr_t;

    function automatic rb_idx_t rb_reduce(input rb_cnt_t v, input rb_cnt_t cnt);
        rb_cnt_t r;
        r = v % cnt;
        return r[RB_IW-1:0];
    endfunction

    function automatic rb_idx_t rb_next(input rb_idx_t p, input rb_cnt_t cnt);
        if ({1'b0, p} + rb_cnt_t'(1) == cnt)
            return '0;
        return p + rb_idx_t'(1);
    endfunction

    function automatic rb_byte_t rb_merge(input rb_byte_t old_v, input rb_byte_t new_v,
                                          input rb_byte_t wm);
        return (old_v & ~wm) | (new_v & wm);
    endfunction

    function automatic logic rb_in_range(input rb_idx_t idx, input int n);
        return {1'b0, idx} < rb_cnt_t'(n);
    endfunction

    function automatic rb_cnt_t rb_clamp_cnt(input rb_byte_t field, input int n);
        rb_cnt_t c;
        c = {1'b0, field} + rb_cnt_t'(1);
        if (c > rb_cnt_t'(n))
            c = rb_cnt_t'(n);
        return c;
    endfunction

endpackage

// File: rtl/rb_store.sv
module rb_store
    import rb_pkg::*;
#(
    parameter int NUM_REGS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  rb_wr_t      bus_wr,
    input  rb_host_wr_t host_wr,
    input  rb_idx_t     bus_idx,
    input  rb_idx_t     host_idx,
    output rb_byte_t    bus_data,
    output rb_byte_t    bus_rmask,
    output rb_entry_t   host_ent
);

    localparam rb_entry_t RST_ENT = '{data: 8'hFF, rmask: 8'hFF, wmask: 8'hFF};

    rb_entry_t mem [0:NUM_REGS-1];

    // Host update first, bus update last: the bus wins a same-entry clash.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                mem[i] <= RST_ENT;
        end else begin
            if (host_wr.en && rb_in_range(host_wr.idx, NUM_REGS)) begin
                case (host_wr.sel)
                    HS_DATA:  mem[host_wr.idx].data  <= host_wr.val;
                    HS_RMASK: mem[host_wr.idx].rmask <= host_wr.val;
                    HS_WMASK: mem[host_wr.idx].wmask <= host_wr.val;
                    default:  ;
                endcase
            end
            if (bus_wr.en && rb_in_range(bus_wr.idx, NUM_REGS))
                mem[bus_wr.idx].data <= rb_merge(mem[bus_wr.idx].data, bus_wr.val,
                                                 mem[bus_wr.idx].wmask);
        end
    end

    always_comb begin
        bus_data  = '0;
        bus_rmask = '0;
        if (rb_in_range(bus_idx, NUM_REGS)) begin
            bus_data  = mem[bus_idx].data;
            bus_rmask = mem[bus_idx].rmask;
        end
    end

    always_comb begin
        host_ent = '0;
        if (rb_in_range(host_idx, NUM_REGS))
            host_ent = mem[host_idx];
    end

endmodule

// File: rtl/rb_ptr_ctrl.sv
module rb_ptr_ctrl
    import rb_pkg::*;
#(
    parameter int NUM_REGS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_valid,
    input  bus_ev_e    ev_kind,
    input  rb_byte_t   ev_data,
    input  logic       ctl_en,
    input  rb_idx_t    ctl_addr,
    input  rb_byte_t   ctl_val,
    output rb_idx_t    ptr_q,
    output rb_cnt_t    cnt_q,
    output addr_mode_e mode_q,
    output rb_wr_t     bus_wr
);

    logic    first_q;
    rb_cnt_t new_cnt;

    assign new_cnt = rb_clamp_cnt(ctl_val, NUM_REGS);

    always_comb begin
        bus_wr.en  = ev_valid && (ev_kind == EV_WRITE) &&
                     ((mode_q == MODE_ZERO) || !first_q);
        bus_wr.idx = ptr_q;
        bus_wr.val = ev_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            cnt_q   <= rb_cnt_t'(NUM_REGS);
            mode_q  <= MODE_PTR;
            first_q <= 1'b1;
        end else if (ev_valid) begin
            case (ev_kind)
                EV_START: begin
                    first_q <= 1'b1;
                    if (mode_q == MODE_ZERO)
                        ptr_q <= '0;
                end
                EV_WRITE: begin
                    first_q <= 1'b0;
                    if (mode_q == MODE_PTR && first_q)
                        ptr_q <= rb_reduce({1'b0, ev_data}, cnt_q);
                    else
                        ptr_q <= rb_next(ptr_q, cnt_q);
                end
                EV_READ:  ptr_q <= rb_next(ptr_q, cnt_q);
                default:  ;
            endcase
        end else if (ctl_en) begin
            case (ctl_addr)
                CTRL_PTR:  ptr_q  <= rb_reduce({1'b0, ctl_val}, cnt_q);
                CTRL_CNT: begin
                    cnt_q <= new_cnt;
                    ptr_q <= rb_reduce({1'b0, ptr_q}, new_cnt);
                end
                CTRL_MODE: mode_q <= addr_mode_e'(ctl_val[0]);
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_tgt_regbank.sv
module i2c_tgt_regbank
    import rb_pkg::*;
#(
    parameter int NUM_REGS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_ev_valid,
    input  logic [1:0] bus_ev_kind,
    input  logic [7:0] bus_ev_data,
    output logic [7:0] bus_rdata,
    input  logic       host_req,
    input  logic       host_we,
    input  logic [1:0] host_sel,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic       host_ack,
    output logic [7:0] host_rdata
);

    host_sel_e   sel;
    bus_ev_e     ev_kind;
    rb_idx_t     ptr_q;
    rb_cnt_t     cnt_q;
    addr_mode_e  mode_q;
    rb_wr_t      bus_wr;
    rb_host_wr_t host_wr;
    rb_byte_t    cur_data;
    rb_byte_t    cur_rmask;
    rb_entry_t   host_ent;
    rb_cnt_t     cnt_m1;
    logic        clash_data;
    logic        clash_ctrl;
    logic        ctl_en;

    assign sel     = host_sel_e'(host_sel);
    assign ev_kind = bus_ev_e'(bus_ev_kind);

    // Stall rules: the bus owns a register it writes this cycle and owns
    // the pointer state whenever it presents an event.
    assign clash_data = host_req && host_we && (sel != HS_CTRL) && bus_wr.en &&
                        (host_addr == bus_wr.idx);
    assign clash_ctrl = host_req && host_we && (sel == HS_CTRL) && bus_ev_valid;
    assign host_ack   = host_req && !clash_data && !clash_ctrl;

    always_comb begin
        host_wr.en  = host_ack && host_we && (sel != HS_CTRL);
        host_wr.sel = sel;
        host_wr.idx = host_addr;
        host_wr.val = host_wdata;
    end

    assign ctl_en = host_ack && host_we && (sel == HS_CTRL);

    rb_ptr_ctrl #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (bus_ev_valid),
        .ev_kind  (ev_kind),
        .ev_data  (bus_ev_data),
        .ctl_en   (ctl_en),
        .ctl_addr (host_addr),
        .ctl_val  (host_wdata),
        .ptr_q    (ptr_q),
        .cnt_q    (cnt_q),
        .mode_q   (mode_q),
        .bus_wr   (bus_wr)
    );

    rb_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .host_wr   (host_wr),
        .bus_idx   (ptr_q),
        .host_idx  (host_addr),
        .bus_data  (cur_data),
        .bus_rmask (cur_rmask),
        .host_ent  (host_ent)
    );

    assign bus_rdata = cur_data & cur_rmask;
    assign cnt_m1    = cnt_q - rb_cnt_t'(1);

    always_comb begin
        host_rdata = '0;
        case (sel)
            HS_DATA:  host_rdata = host_ent.data;
            HS_RMASK: host_rdata = host_ent.rmask;
            HS_WMASK: host_rdata = host_ent.wmask;
            default: begin
                case (host_addr)
                    CTRL_PTR:  host_rdata = ptr_q;
                    CTRL_CNT:  host_rdata = cnt_m1[RB_DW-1:0];
                    CTRL_MODE: host_rdata = {7'd0, mode_q};
                    default:   host_rdata = '0;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int NUM_REGS = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       ev_valid,
    input logic [1:0] ev_kind,
    input logic [7:0] ptr,
    input logic [8:0] cnt,
    input logic       mode,
    input logic       host_req,
    input logic       host_we,
    input logic [1:0] host_sel,
    input logic       host_ack
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ptr == 8'd0 && mode == 1'b0 && cnt == 9'(NUM_REGS)));

    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        (cnt != 9'd0 && cnt <= 9'(NUM_REGS)));

    a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ptr} < cnt));

    a_r5_read_advance: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == 2'd2) |=>
        (ptr == (({1'b0, $past(ptr)} + 9'd1 == $past(cnt)) ? 8'd0 : $past(ptr) + 8'd1)));

    a_r6_zero_start: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == 2'd0 && mode) |=> (ptr == 8'd0));

    a_r11_ctrl_stall: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_sel == 2'd3 && ev_valid) |-> !host_ack);

    a_r12_stop_hold: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == 2'd3) |=> $stable(ptr));

endmodule

bind i2c_tgt_regbank rb_checker #(.NUM_REGS(NUM_REGS)) u_rb_checker (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (bus_ev_valid),
    .ev_kind  (bus_ev_kind),
    .ptr      (ptr_q),
    .cnt      (cnt_q),
    .mode     (mode_q),
    .host_req (host_req),
    .host_we  (host_we),
    .host_sel (host_sel),
    .host_ack (host_ack)
);

// File: tb/i2c_tgt_regbank_bench.sv
module i2c_tgt_regbank_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_ev_valid;
    logic [1:0] bus_ev_kind;
    logic [7:0] bus_ev_data;
    logic [7:0] bus_rdata;
    logic       host_req;
    logic       host_we;
    logic [1:0] host_sel;
    logic [7:0] host_addr;
    logic [7:0] host_wdata;
    logic       host_ack;
    logic [7:0] host_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    i2c_tgt_regbank u_i2c_tgt_regbank (
        .clk          (clk),
        .rst          (rst),
        .bus_ev_valid (bus_ev_valid),
        .bus_ev_kind  (bus_ev_kind),
        .bus_ev_data  (bus_ev_data),
        .bus_rdata    (bus_rdata),
        .host_req     (host_req),
        .host_we      (host_we),
        .host_sel     (host_sel),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_ack     (host_ack),
        .host_rdata   (host_rdata)
    );

    // op: 0 host write, 1 host read+check, 2 bus event (kind in sel), 3 bus read+check
    typedef struct packed {
        logic [1:0] op;
        logic [1:0] sel;
        logic [7:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 8'h10, 8'hA5, 4'd9},
        '{2'd1, 2'd0, 8'h10, 8'hA5, 4'd9},
        '{2'd2, 2'd0, 8'h00, 8'h00, 4'd4},
        '{2'd2, 2'd1, 8'h00, 8'h10, 4'd4},
        '{2'd2, 2'd0, 8'h00, 8'h00, 4'd4},
        '{2'd3, 2'd0, 8'h00, 8'hA5, 4'd5},
        '{2'd3, 2'd0, 8'h00, 8'hFF, 4'd5},
        '{2'd0, 2'd1, 8'h20, 8'h3F, 4'd7},
        '{2'd2, 2'd0, 8'h00, 8'h00, 4'd7},
        '{2'd2, 2'd1, 8'h00, 8'h20, 4'd7},
        '{2'd2, 2'd0, 8'h00, 8'h00, 4'd7},
        '{2'd3, 2'd0, 8'h00, 8'h3F, 4'd7},
        '{2'd1, 2'd0, 8'h20, 8'hFF, 4'd9},
        '{2'd0, 2'd2, 8'h21, 8'hF0, 4'd8},
        '{2'd0, 2'd0, 8'h21, 8'h00, 4'd8},
        '{2'd2, 2'd0, 8'h00, 8'h00, 4'd8},
        '{2'd2, 2'd1, 8'h00, 8'h21, 4'd8},
        '{2'd2, 2'd1, 8'h00, 8'hFF, 4'd8},
        '{2'd2, 2'd3, 8'h00, 8'h00, 4'd8},
        '{2'd1, 2'd0, 8'h21, 8'hF0, 4'd8},
        '{2'd1, 2'd3, 8'h00, 8'h22, 4'd5},
        '{2'd2, 2'd0, 8'h00, 8'h00, 4'd4},
        '{2'd2, 2'd1, 8'h00, 8'h30, 4'd4},
        '{2'd2, 2'd1, 8'h00, 8'h11, 4'd4},
        '{2'd2, 2'd1, 8'h00, 8'h22, 4'd4},
        '{2'd2, 2'd3, 8'h00, 8'h00, 4'd4},
        '{2'd1, 2'd0, 8'h30, 8'h11, 4'd4},
        '{2'd1, 2'd0, 8'h31, 8'h22, 4'd4}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_ev_valid = 1'b0;
        bus_ev_kind  = 2'd0;
        bus_ev_data  = 8'd0;
        host_req     = 1'b0;
        host_we      = 1'b0;
        host_sel     = 2'd0;
        host_addr    = 8'd0;
        host_wdata   = 8'd0;
    endtask

    task automatic host_wr(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d,
                           output logic ack);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_sel = s; host_addr = a; host_wdata = d;
        #1 ack = host_ack;
        @(posedge clk); #1;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] s, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_sel = s; host_addr = a;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    task automatic bus_ev(input logic [1:0] k, input logic [7:0] d);
        @(negedge clk);
        bus_ev_valid = 1'b1; bus_ev_kind = k; bus_ev_data = d;
        @(posedge clk); #1;
        bus_ev_valid = 1'b0;
    endtask

    task automatic bus_rd(output logic [7:0] d);
        @(negedge clk);
        bus_ev_valid = 1'b1; bus_ev_kind = 2'd2;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_ev_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       ack;
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        host_rd(2'd0, 8'h00, rd); check("R1 data", rd, 8'hFF);
        host_rd(2'd0, 8'hFF, rd); check("R1 data top", rd, 8'hFF);
        host_rd(2'd1, 8'h07, rd); check("R1 rmask", rd, 8'hFF);
        host_rd(2'd2, 8'h07, rd); check("R1 wmask", rd, 8'hFF);
        host_rd(2'd3, 8'h00, rd); check("R1 ptr", rd, 8'h00);
        host_rd(2'd3, 8'h01, rd); check("R1 count", rd, 8'hFF);
        host_rd(2'd3, 8'h02, rd); check("R1 mode", rd, 8'h00);

        // Vector walk: R4 R5 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: host_wr(VECS[i].sel, VECS[i].addr, VECS[i].data, ack);
                2'd1: begin
                    host_rd(VECS[i].sel, VECS[i].addr, rd);
                    check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].data);
                end
                2'd2: bus_ev(VECS[i].sel, VECS[i].data);
                default: begin
                    bus_rd(rd);
                    check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].data);
                end
            endcase
        end

        // R2 / R3 count, modulo and wrap
        host_wr(2'd3, 8'h01, 8'h07, ack);
        host_rd(2'd3, 8'h01, rd); check("R2 count readback", rd, 8'h07);
        host_wr(2'd3, 8'h00, 8'h0A, ack);
        host_rd(2'd3, 8'h00, rd); check("R3 host ptr modulo", rd, 8'h02);
        host_wr(2'd3, 8'h00, 8'h07, ack);
        bus_rd(rd);
        host_rd(2'd3, 8'h00, rd); check("R3 wrap to zero", rd, 8'h00);
        bus_ev(2'd0, 8'h00);
        bus_ev(2'd1, 8'h0D);
        host_rd(2'd3, 8'h00, rd); check("R3 bus ptr modulo", rd, 8'h05);
        host_wr(2'd3, 8'h01, 8'hFF, ack);
        host_rd(2'd3, 8'h01, rd); check("R2 count restore", rd, 8'hFF);

        // R6 zero mode
        host_wr(2'd3, 8'h02, 8'h01, ack);
        host_rd(2'd3, 8'h02, rd); check("R10 mode readback", rd, 8'h01);
        host_wr(2'd0, 8'h00, 8'h01, ack);
        host_wr(2'd0, 8'h01, 8'h02, ack);
        host_wr(2'd3, 8'h00, 8'h40, ack);
        bus_ev(2'd0, 8'h00);
        bus_rd(rd); check("R6 read reg0", rd, 8'h01);
        bus_rd(rd); check("R6 read reg1", rd, 8'h02);
        bus_ev(2'd0, 8'h00);
        bus_ev(2'd1, 8'h77);
        bus_ev(2'd1, 8'h88);
        bus_ev(2'd3, 8'h00);
        host_rd(2'd0, 8'h00, rd); check("R6 first byte stored", rd, 8'h77);
        host_rd(2'd0, 8'h01, rd); check("R6 second byte stored", rd, 8'h88);
        host_wr(2'd3, 8'h02, 8'h00, ack);

        // R11 same-register collision
        bus_ev(2'd0, 8'h00);
        bus_ev(2'd1, 8'h50);
        @(negedge clk);
        bus_ev_valid = 1'b1; bus_ev_kind = 2'd1; bus_ev_data = 8'h5A;
        host_req = 1'b1; host_we = 1'b1; host_sel = 2'd0; host_addr = 8'h50; host_wdata = 8'hC3;
        #1 check("R11 data clash ack", {7'd0, host_ack}, 8'h00);
        @(posedge clk); #1;
        idle_inputs();
        host_rd(2'd0, 8'h50, rd); check("R11 bus write kept", rd, 8'h5A);
        host_wr(2'd0, 8'h50, 8'hC3, ack);
        check("R11 retry ack", {7'd0, ack}, 8'h01);
        host_rd(2'd0, 8'h50, rd); check("R11 retry landed", rd, 8'hC3);

        // R11 control stall during a stop; R12 stop holds pointer
        @(negedge clk);
        bus_ev_valid = 1'b1; bus_ev_kind = 2'd3;
        host_req = 1'b1; host_we = 1'b1; host_sel = 2'd3; host_addr = 8'h00; host_wdata = 8'h33;
        #1 check("R11 ctrl clash ack", {7'd0, host_ack}, 8'h00);
        @(posedge clk); #1;
        idle_inputs();
        host_rd(2'd3, 8'h00, rd); check("R12 stop keeps ptr", rd, 8'h51);

        // R12 combinational read path; R9 host write ignores masks
        host_wr(2'd2, 8'h51, 8'h00, ack);
        host_wr(2'd0, 8'h51, 8'h6C, ack);
        @(negedge clk); #1;
        check("R12 rdata same cycle", bus_rdata, 8'h6C);
        host_rd(2'd0, 8'h51, rd); check("R9 write past wmask", rd, 8'h6C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule